// File: doc/BRIEF.md
# Period Timer with Extended Overflow Count

This block is a 16-bit up-counting timer that restarts from zero whenever its value is at or above a programmable period. Every restart steps a 20-bit overflow counter, so the pair forms a long time base. Software reaches the block over a byte-wide register port with address, write strobe, write data and read strobe. Read data comes back on the following cycle.

A capture input latches the timer value and the overflow count on the same clock edge. The period address and the overflow compare address both split by direction: a write programs the setting, and a read returns the latched capture. The overflow count is loaded in three byte writes that take effect together on the top byte. If an overflow lands on the same edge as that commit, one is added to the loaded value. Three interrupt pulses are each gated by a mask bit: an external timer-compare match, a timer overflow, and the overflow count reaching a programmed value.

Register addresses: 0 control (bit 0 = run), 1 period low / captured timer low, 2 period high / captured timer high, 3/4/5 overflow count bytes, 6/7/8 overflow compare / captured overflow count.

Top module: `mac_tick_timer`

## Requirements
- R1: After reset the run bit, all masks, the overflow count, the overflow compare value and both capture registers are zero, and the period is 0xFFFF.
- R2: While the run bit is 1, the timer rises by one on each clock. On an edge where the timer is greater than or equal to the period, it goes to zero instead and the overflow count rises by one on that same edge.
- R3: While the run bit is 0, the timer and the overflow count hold their values.
- R4: Writes to addresses 3 and 4 only stage bits [7:0] and [15:8] of a new overflow count. A write to address 5 loads the count with {wdata[3:0], stage 4, stage 3}. Reads of 3, 4 and 5 return the live count, with address 5 giving {4'b0, count[19:16]}.
- R5: If the load from address 5 falls on an overflow edge, the count takes the loaded value plus one.
- R6: Writes to addresses 1 and 2 set period bits [7:0] and [15:8]. Reads of those addresses return the captured timer bytes, not the period.
- R7: A capture pulse latches the timer and the overflow count as they stand before the same edge.
- R8: Writes to 6, 7 and the low nibble of 8 set compare bits [7:0], [15:8] and [19:16]. Reads of 6 and 7 return captured count bytes. A read of 8 returns {timer-compare mask, overflow mask, count-compare mask, 0, captured count[19:16]}, with the masks in bits 7, 6 and 5 and bit 4 always 0.
- R9: irq_ovf is high for the one cycle after each overflow edge when mask bit 6 is set, and stays low otherwise.
- R10: irq_ofcmp is high for the one cycle after an overflow edge that leaves the count equal to the compare value, when mask bit 5 is set.
- R11: irq_tcmp is high for the one cycle after a cycle with tcmp_hit high, when mask bit 7 is set.
- R12: rdata is registered. It carries the addressed value in the cycle after rd_en and is zero after any cycle without rd_en. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, one cycle after rd_en |
| capture_in | input | 1 | Capture pulse |
| tcmp_hit | input | 1 | Match pulse from the external timer compare unit |
| irq_tcmp | output | 1 | Masked timer-compare interrupt pulse |
| irq_ovf | output | 1 | Masked overflow interrupt pulse |
| irq_ofcmp | output | 1 | Masked overflow-count-compare interrupt pulse |

## Verification
A register write takes effect at the edge that ends its strobe cycle. A run-bit change is therefore seen by the counters one edge later, so a run window opened and closed K cycles apart gives exactly K timer steps. The bench builds its expected timer and count values from that rule. Read results are due one cycle after the strobe: the driver queues each expected byte, and a monitor compares it at the falling edge that follows the registered read. Interrupt pulses are due one cycle after their cause. They are sampled at falling edges and counted over the run window plus a three-cycle tail.

// File: rtl/mt_pkg.sv
// Shared widths, register addresses and mask layout for the period timer.
package mt_pkg;
    parameter int TMR_W  = 16;
    parameter int OVF_W  = 20;
    parameter int ADDR_W = 4;
    localparam int TOP_W = OVF_W - 16;   // overflow bits held in the top byte register

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PER_L = 4'd1;
    localparam logic [ADDR_W-1:0] A_PER_H = 4'd2;
    localparam logic [ADDR_W-1:0] A_OVC_L = 4'd3;
    localparam logic [ADDR_W-1:0] A_OVC_M = 4'd4;
    localparam logic [ADDR_W-1:0] A_OVC_H = 4'd5;
    localparam logic [ADDR_W-1:0] A_OCC_L = 4'd6;
    localparam logic [ADDR_W-1:0] A_OCC_M = 4'd7;
    localparam logic [ADDR_W-1:0] A_OCC_H = 4'd8;

    // Interrupt masks, packed in the order they occupy bits 7..5 of the top compare register
    typedef struct packed {
        logic tcmp;
        logic ovf;
        logic ofcmp;
    } irq_mask_t;
endpackage

// File: rtl/mt_regs.sv
// Register file and bus port of the period timer.
// Holds run, period, overflow-count staging, overflow compare value and masks,
// and returns read data one cycle after rd_en. Assumes single-cycle strobes.
module mt_regs
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic [TMR_W-1:0]  cap_tmr,
    input  logic [OVF_W-1:0]  cap_ovf,
    input  logic [OVF_W-1:0]  ovf_cnt,
    output logic              run,
    output logic [TMR_W-1:0]  period,
    output logic              ld_stb,
    output logic [OVF_W-1:0]  ld_val,
    output logic [OVF_W-1:0]  cmp_val,
    output irq_mask_t         mask
);
    logic [7:0]       stg_lo, stg_mid;
    logic [7:0]       rd_mux;
    logic [7:0]       rdata_q;
    logic [TOP_W-1:0] nib_w;

    assign nib_w  = wdata[TOP_W-1:0];
    assign ld_stb = wr_en && (addr == A_OVC_H);
    assign ld_val = {nib_w, stg_mid, stg_lo};
    assign rdata  = rdata_q;

    // Control, period, staging, compare and mask registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            period  <= '1;
            stg_lo  <= '0;
            stg_mid <= '0;
            cmp_val <= '0;
            mask    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:  run           <= wdata[0];
                A_PER_L: period[7:0]   <= wdata;
                A_PER_H: period[15:8]  <= wdata;
                A_OVC_L: stg_lo        <= wdata;
                A_OVC_M: stg_mid       <= wdata;
                A_OCC_L: cmp_val[7:0]  <= wdata;
                A_OCC_M: cmp_val[15:8] <= wdata;
                A_OCC_H: begin
                    cmp_val[OVF_W-1:16] <= nib_w;
                    mask                <= wdata[7:5];
                end
                default: ;
            endcase
        end
    end

    // Read selection: direction-split addresses return captured values
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CTRL:  rd_mux = {7'd0, run};
            A_PER_L: rd_mux = cap_tmr[7:0];
            A_PER_H: rd_mux = cap_tmr[15:8];
            A_OVC_L: rd_mux = ovf_cnt[7:0];
            A_OVC_M: rd_mux = ovf_cnt[15:8];
            A_OVC_H: rd_mux = {{(8-TOP_W){1'b0}}, ovf_cnt[OVF_W-1:16]};
            A_OCC_L: rd_mux = cap_ovf[7:0];
            A_OCC_M: rd_mux = cap_ovf[15:8];
            A_OCC_H: rd_mux = {mask, 1'b0, cap_ovf[OVF_W-1:16]};
            default: rd_mux = '0;
        endcase
    end

    // Registered read port, zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_en ? rd_mux : 8'd0;
    end

    // R12: no read strobe leaves the read data at zero
    assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == 8'd0));
    // R8: bit 4 of the top compare register always reads zero
    assert_rsvd_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_OCC_H) |=> (rdata[4] == 1'b0));
endmodule

// File: rtl/mt_core.sv
// Timer and overflow counter datapath.
// Counts while run is set, restarts at or above the period, steps the 20-bit
// overflow count, honours the staged count load (plus one on a coincident
// overflow) and latches both values on capture. Assumes ld_stb is one cycle.
module mt_core
    import mt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMR_W-1:0] period,
    input  logic             ld_stb,
    input  logic [OVF_W-1:0] ld_val,
    input  logic             capture_in,
    output logic [TMR_W-1:0] tmr,
    output logic [OVF_W-1:0] ovf_cnt,
    output logic             ovf_evt,
    output logic [OVF_W-1:0] ovf_nxt,
    output logic [TMR_W-1:0] cap_tmr,
    output logic [OVF_W-1:0] cap_ovf
);
    assign ovf_evt = run && (tmr >= period);

    // Next overflow count: a load wins, and a coincident overflow adds one to it
    always_comb begin
        if (ld_stb)       ovf_nxt = ld_val + OVF_W'(ovf_evt);
        else if (ovf_evt) ovf_nxt = ovf_cnt + 1'b1;
        else              ovf_nxt = ovf_cnt;
    end

    // Timer and overflow count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr     <= '0;
            ovf_cnt <= '0;
        end else begin
            if (run) tmr <= ovf_evt ? '0 : tmr + 1'b1;
            ovf_cnt <= ovf_nxt;
        end
    end

    // Capture latches the timer and the overflow count on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_tmr <= '0;
            cap_ovf <= '0;
        end else if (capture_in) begin
            cap_tmr <= tmr;
            cap_ovf <= ovf_cnt;
        end
    end

    // R2: at or above the period the timer restarts from zero
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tmr >= period) |=> (tmr == '0));
    // R2: below the period the timer steps by one and the count is untouched
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tmr < period && !ld_stb) |=> (tmr == $past(tmr) + 1'b1) && $stable(ovf_cnt));
    // R3: stopped counters hold
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_stb) |=> $stable(tmr) && $stable(ovf_cnt));
    // R5: load that meets an overflow keeps the increment
    assert_load_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && run && tmr >= period) |=> (ovf_cnt == $past(ld_val) + 1'b1));
    // R7: capture holds the pre-edge pair
    assert_capture_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        capture_in |=> (cap_tmr == $past(tmr)) && (cap_ovf == $past(ovf_cnt)));
endmodule

// File: rtl/mt_irq.sv
// Interrupt pulse generation.
// Registers one-cycle pulses for a timer-compare match, a timer overflow and
// the overflow count reaching its compare value, each gated by its mask.
module mt_irq
    import mt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tcmp_hit,
    input  logic             ovf_evt,
    input  logic [OVF_W-1:0] ovf_nxt,
    input  logic [OVF_W-1:0] cmp_val,
    input  irq_mask_t        mask,
    output logic             irq_tcmp,
    output logic             irq_ovf,
    output logic             irq_ofcmp
);
    // Masked event pulses, one cycle after their cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tcmp  <= 1'b0;
            irq_ovf   <= 1'b0;
            irq_ofcmp <= 1'b0;
        end else begin
            irq_tcmp  <= mask.tcmp && tcmp_hit;
            irq_ovf   <= mask.ovf && ovf_evt;
            irq_ofcmp <= mask.ofcmp && ovf_evt && (ovf_nxt == cmp_val);
        end
    end

    // R9: overflow pulse never appears with its mask clear
    assert_ovf_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask.ovf |=> !irq_ovf);
    // R10: count-compare pulse only follows an overflow edge
    assert_ofcmp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_evt |=> !irq_ofcmp);
    // R11: timer-compare pulse follows its match input
    assert_tcmp_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask.tcmp && tcmp_hit) |=> irq_tcmp);
endmodule

// File: rtl/mac_tick_timer.sv
// Top of the period timer with extended overflow count.
// Connects the register file, the counting datapath and the interrupt stage.
// Assumes synchronous active-low reset and single-cycle bus strobes.
module mac_tick_timer
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic              capture_in,
    input  logic              tcmp_hit,
    output logic              irq_tcmp,
    output logic              irq_ovf,
    output logic              irq_ofcmp
);
    logic             run, ld_stb, ovf_evt;
    logic [TMR_W-1:0] period, tmr, cap_tmr;
    logic [OVF_W-1:0] ld_val, cmp_val, ovf_cnt, ovf_nxt, cap_ovf;
    irq_mask_t        mask;

    mt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .cap_tmr(cap_tmr), .cap_ovf(cap_ovf),
        .ovf_cnt(ovf_cnt), .run(run), .period(period), .ld_stb(ld_stb),
        .ld_val(ld_val), .cmp_val(cmp_val), .mask(mask)
    );

    mt_core u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .period(period), .ld_stb(ld_stb),
        .ld_val(ld_val), .capture_in(capture_in), .tmr(tmr), .ovf_cnt(ovf_cnt),
        .ovf_evt(ovf_evt), .ovf_nxt(ovf_nxt), .cap_tmr(cap_tmr), .cap_ovf(cap_ovf)
    );

    mt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .tcmp_hit(tcmp_hit), .ovf_evt(ovf_evt),
        .ovf_nxt(ovf_nxt), .cmp_val(cmp_val), .mask(mask), .irq_tcmp(irq_tcmp),
        .irq_ovf(irq_ovf), .irq_ofcmp(irq_ofcmp)
    );
endmodule

// File: tb/mac_tick_timer_tb.sv
// Scoreboard bench: the read driver queues expected bytes, a monitor compares them.
module mac_tick_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       capture_in = 1'b0;
    logic       tcmp_hit = 1'b0;
    logic       irq_tcmp, irq_ovf, irq_ofcmp;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       seen_rd = 1'b0;
    logic       win = 1'b0;
    int n_ovf = 0, n_ofc = 0, n_dbl = 0;
    logic prev_ovf = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mac_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .capture_in(capture_in), .tcmp_hit(tcmp_hit),
        .irq_tcmp(irq_tcmp), .irq_ovf(irq_ovf), .irq_ofcmp(irq_ofcmp)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic capture();
        capture_in = 1'b1;
        @(negedge clk);
        capture_in = 1'b0;
    endtask

    // Run for a window of k+1 timer steps, then a three-cycle tail for late pulses
    task automatic run_window(input int k);
        win = 1'b1;
        wr(4'd0, 8'h01);
        repeat (k) @(negedge clk);
        wr(4'd0, 8'h00);
        repeat (3) @(negedge clk);
        win = 1'b0;
    endtask

    always @(posedge clk) seen_rd <= rd_en;

    // Monitor: compare each registered read against the queued expectation
    always @(negedge clk) begin
        if (seen_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata == e, t, rdata, e);
        end
        if (win) begin
            if (irq_ovf) n_ovf++;
            if (irq_ofcmp) n_ofc++;
            if (irq_ovf && prev_ovf) n_dbl++;
        end
        prev_ovf <= irq_ovf;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen through the read port
        rd(4'd0, 8'h00, "R1 run bit");
        rd(4'd1, 8'h00, "R1 capture low");
        rd(4'd3, 8'h00, "R1 count low");
        rd(4'd8, 8'h00, "R1 masks");
        @(negedge clk);
        check(rdata == 8'h00, "R12 idle rdata", rdata, 0);
        rd(4'd9, 8'h00, "R12 unused address");

        // R2/R6: period 9, 25 steps -> two overflows, timer 5
        wr(4'd1, 8'd9); wr(4'd2, 8'd0);
        run_window(24);
        rd(4'd3, 8'h02, "R2 overflow count");
        capture();
        rd(4'd1, 8'h05, "R6 read gives captured timer low");
        rd(4'd2, 8'h00, "R6 captured timer high");
        rd(4'd6, 8'h02, "R7 captured count low");
        // R3: idle hold
        repeat (5) @(negedge clk);
        capture();
        rd(4'd1, 8'h05, "R3 timer held");
        rd(4'd3, 8'h02, "R3 count held");
        // R8: compare write does not show on read; masks and bit 4
        wr(4'd6, 8'hAA);
        wr(4'd8, 8'hFF);
        rd(4'd6, 8'h02, "R8 read gives captured count");
        rd(4'd8, 8'hE0, "R8 masks with bit4 zero");
        wr(4'd8, 8'h00);

        // R4: staged load commits only on the top byte
        wr(4'd3, 8'h34); wr(4'd4, 8'h12);
        rd(4'd3, 8'h02, "R4 no commit before top byte");
        wr(4'd5, 8'h05);
        rd(4'd3, 8'h34, "R4 count low");
        rd(4'd4, 8'h12, "R4 count mid");
        rd(4'd5, 8'h05, "R4 count top");

        // R5: period 0 overflows on every step; load lands on an overflow
        wr(4'd1, 8'd0); wr(4'd2, 8'd0);
        wr(4'd3, 8'h10); wr(4'd4, 8'h00);
        wr(4'd0, 8'h01);
        wr(4'd5, 8'h00);
        wr(4'd0, 8'h00);
        rd(4'd3, 8'h12, "R5 load plus one then one more step");
        rd(4'd5, 8'h00, "R5 count top");

        // R9/R10: period 9, compare 0x14, masks ovf and count-compare
        wr(4'd1, 8'd9); wr(4'd2, 8'd0);
        wr(4'd6, 8'h14); wr(4'd7, 8'h00); wr(4'd8, 8'h60);
        n_ovf = 0; n_ofc = 0; n_dbl = 0;
        run_window(24);
        check(n_ovf == 2, "R9 overflow pulses", n_ovf, 2);
        check(n_dbl == 0, "R9 pulse width one cycle", n_dbl, 0);
        check(n_ofc == 1, "R10 count-compare pulses", n_ofc, 1);
        rd(4'd3, 8'h14, "R10 count at compare");
        // R9/R10 masked: no pulses
        wr(4'd8, 8'h00);
        n_ovf = 0; n_ofc = 0;
        run_window(24);
        check(n_ovf == 0, "R9 masked overflow", n_ovf, 0);
        check(n_ofc == 0, "R10 masked count-compare", n_ofc, 0);

        // R11: timer-compare pulse gated by bit 7
        wr(4'd8, 8'h80);
        tcmp_hit = 1'b1;
        @(negedge clk);
        tcmp_hit = 1'b0;
        check(irq_tcmp == 1'b1, "R11 pulse high", irq_tcmp, 1);
        @(negedge clk);
        check(irq_tcmp == 1'b0, "R11 pulse ends", irq_tcmp, 0);
        wr(4'd8, 8'h00);
        tcmp_hit = 1'b1;
        @(negedge clk);
        tcmp_hit = 1'b0;
        check(irq_tcmp == 1'b0, "R11 masked", irq_tcmp, 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule